// File: doc/BRIEF.md
# Console Address Formation Unit

This block sits at the front of a debug console port and produces the address and qualifiers for every console memory command. It holds a word address register of `ADDR_W` bits (22 by default), stored without the byte bit, together with two mapping-enable flags. It also holds a small window register for the I/O page, made of a base field and a byte-enable. Three write strobes load these registers from one data word. The low-word write loads the low address bits and clears everything above them, flags included. The high-word write loads the upper address bits and the two flags. The window write loads the base and the byte-enable.

Each command is issued in one of two modes. In normal mode the held address goes out with a full-word byte-enable and the stored flags. In window mode an I/O-page address is built from forced top bits, the stored base and a per-command offset. That address goes out with the remote-access qualifier set, the stored window byte-enable, and both flags cleared. After a memory command completes, an advance strobe steps the held word address by one.

Top module: `console_addr_unit`

## Requirements
- R1: A synchronous reset, which wins over every strobe, clears the address register, both flags and the window base, and sets the window byte-enable to 11.
- R2: A low-word write loads word-address bits 14:0 (byte bits 15:1) from `wdata[15:1]`. In the same edge it clears word-address bits 20:15 (byte bits 21:16) and both flags.
- R3: A high-word write loads byte bits 21:16 from `wdata[5:0]`, the 22-bit flag from `wdata[6]` and the map flag from `wdata[7]`, and keeps the low address bits.
- R4: A window write stores the base from `wdata[12:6]` and the byte-enable from `wdata[1:0]`. A written byte-enable of 00 is stored as 11.
- R5: In window mode the byte address is formed as follows: bits 21:16 are 0, bits 15:13 are 111, bits 12:6 are the stored base and bits 5:1 are `win_off[5:1]`. `win_off[0]` is ignored.
- R6: In window mode `remote_o` is 1, `be_o` is the stored window byte-enable, and `ext22_o` and `mapen_o` are 0 whatever the flags hold.
- R7: In normal mode `addr_o` is the held register, `remote_o` is 0, `be_o` is 11, and the two flag outputs follow the stored flags.
- R8: An advance strobe adds one to the 21-bit word address. The carry runs through the high bits, all ones wraps to zero, and the flags are kept.
- R9: Priority is low-word write, then high-word write, then advance. The loser in the same cycle has no effect. A window write acts independently of the other three.
- R10: The outputs follow `win_mode` and `win_off` within the same cycle. Register writes show on the outputs after the clock edge that samples the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_lo | input | 1 | Low address word write strobe |
| wr_hi | input | 1 | High address word write strobe |
| wr_win | input | 1 | Window register write strobe |
| adv | input | 1 | Step the word address by one |
| wdata | input | 16 | Write data shared by the three writes |
| win_mode | input | 1 | 1 selects window mode, 0 normal mode |
| win_off | input | 6 | Per-command window byte offset |
| addr_o | output | 21 | Word address, byte bits 21:1 |
| be_o | output | 2 | Byte enables |
| remote_o | output | 1 | Remote (I/O page) access qualifier |
| ext22_o | output | 1 | 22-bit addressing enable |
| mapen_o | output | 1 | Bus address map enable |

## Verification
A register write or an advance takes effect at the first rising edge that samples its strobe. The bench drives strobes half a period before that edge and reads the outputs a few nanoseconds after it, before the next edge. The mode and offset inputs reach the outputs through logic only. Those checks change the inputs between edges and sample one nanosecond later with no edge in between. That shows the result is due in the same cycle and not one cycle later.

// File: rtl/cafu_pkg.sv
package cafu_pkg;

   localparam logic [1:0] BE_WORD = 2'b11;

   typedef struct packed {
      logic       remote;
      logic [1:0] be;
      logic       ext22;
      logic       mapen;
   } cafu_qual_t;

   function automatic logic [1:0] be_fix(input logic [1:0] be_in);
      return (be_in == 2'b00) ? BE_WORD : be_in;
   endfunction

endpackage

// File: rtl/cafu_addr_reg.sv
module cafu_addr_reg #(
   parameter int ADDR_W = 22,
   parameter int DATA_W = 16,
   parameter bit INC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              adv,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-2:0] addr_q,
   output logic              ext22_q,
   output logic              map_q
);
   localparam int AW   = ADDR_W - 1;
   localparam int LO_W = DATA_W - 1;
   localparam int HI_W = ADDR_W - DATA_W;

   logic adv_eff;

   generate
      if (INC_EN) begin : g_inc
         assign adv_eff = adv;
      end else begin : g_noinc
         wire unused_adv = adv;
         assign adv_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         ext22_q <= 1'b0;
         map_q   <= 1'b0;
      end else if (wr_lo) begin
         addr_q  <= {{HI_W{1'b0}}, wdata[DATA_W-1:1]};
         ext22_q <= 1'b0;
         map_q   <= 1'b0;
      end else if (wr_hi) begin
         addr_q[AW-1:LO_W] <= wdata[HI_W-1:0];
         ext22_q           <= wdata[HI_W];
         map_q             <= wdata[HI_W+1];
      end else if (adv_eff) begin
         addr_q <= addr_q + AW'(1);
      end
   end

   // R2: low write leaves no high bits or flags behind
   p_lo_clear_r2: assert property (@(posedge clk) disable iff (rst)
      wr_lo |=> (addr_q[AW-1:LO_W] == '0 && !ext22_q && !map_q));

   // R3: high write loads upper bits and keeps the low part
   p_hi_load_r3: assert property (@(posedge clk) disable iff (rst)
      (wr_hi && !wr_lo) |=> (addr_q[AW-1:LO_W] == $past(wdata[HI_W-1:0])
                             && $stable(addr_q[LO_W-1:0])));

   // R9: without any strobe the address holds
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!wr_lo && !wr_hi && !adv) |=> $stable(addr_q));

   generate
      if (INC_EN) begin : g_inc_chk
         // R8: advance steps the word address, flags kept
         p_inc_r8: assert property (@(posedge clk) disable iff (rst)
            (adv && !wr_lo && !wr_hi) |=> (addr_q == $past(addr_q) + AW'(1)
                                           && $stable(ext22_q) && $stable(map_q)));
      end
   endgenerate

endmodule

// File: rtl/cafu_win_reg.sv
module cafu_win_reg
   import cafu_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int OFF_W       = 6,
   parameter int IOPAGE_BITS = 3
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic                                    wr_win,
   input  logic [DATA_W-1:0]                       wdata,
   output logic [DATA_W-IOPAGE_BITS-OFF_W-1:0]     base_q,
   output logic [1:0]                              be_q
);
   localparam int BASE_HI = DATA_W - IOPAGE_BITS - 1;

   wire unused_wd = ^{wdata[DATA_W-1:BASE_HI+1], wdata[OFF_W-1:2]};

   always_ff @(posedge clk) begin
      if (rst) begin
         base_q <= '0;
         be_q   <= BE_WORD;
      end else if (wr_win) begin
         base_q <= wdata[BASE_HI:OFF_W];
         be_q   <= be_fix(wdata[1:0]);
      end
   end

   // R4: the stored byte-enable is never empty
   p_be_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
      be_q != 2'b00);

   // R4: an empty written byte-enable becomes a full word
   p_be_zero_fix_r4: assert property (@(posedge clk) disable iff (rst)
      (wr_win && wdata[1:0] == 2'b00) |=> (be_q == BE_WORD));

endmodule

// File: rtl/cafu_out_mux.sv
module cafu_out_mux
   import cafu_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int DATA_W      = 16,
   parameter int OFF_W       = 6,
   parameter int IOPAGE_BITS = 3
) (
   input  logic                                win_mode,
   input  logic [OFF_W-1:0]                    win_off,
   input  logic [ADDR_W-2:0]                   addr_q,
   input  logic                                ext22_q,
   input  logic                                map_q,
   input  logic [DATA_W-IOPAGE_BITS-OFF_W-1:0] base_q,
   input  logic [1:0]                          be_q,
   output logic [ADDR_W-2:0]                   addr_o,
   output cafu_qual_t                          qual_o
);
   localparam int HI_W = ADDR_W - DATA_W;

   logic [ADDR_W-2:0] win_word;

   wire unused_off = win_off[0];

   assign win_word = {{HI_W{1'b0}}, {IOPAGE_BITS{1'b1}}, base_q, win_off[OFF_W-1:1]};

   always_comb begin
      if (win_mode) begin
         addr_o        = win_word;
         qual_o.remote = 1'b1;
         qual_o.be     = be_q;
         qual_o.ext22  = 1'b0;
         qual_o.mapen  = 1'b0;
      end else begin
         addr_o        = addr_q;
         qual_o.remote = 1'b0;
         qual_o.be     = BE_WORD;
         qual_o.ext22  = ext22_q;
         qual_o.mapen  = map_q;
      end
   end

endmodule

// File: rtl/console_addr_unit.sv
module console_addr_unit
   import cafu_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int DATA_W      = 16,
   parameter int OFF_W       = 6,
   parameter int IOPAGE_BITS = 3,
   parameter bit INC_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              wr_win,
   input  logic              adv,
   input  logic [DATA_W-1:0] wdata,
   input  logic              win_mode,
   input  logic [OFF_W-1:0]  win_off,
   output logic [ADDR_W-2:0] addr_o,
   output logic [1:0]        be_o,
   output logic              remote_o,
   output logic              ext22_o,
   output logic              mapen_o
);
   localparam int HI_W   = ADDR_W - DATA_W;
   localparam int BASE_W = DATA_W - IOPAGE_BITS - OFF_W;

   generate
      if (ADDR_W <= DATA_W || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must exceed DATA_W and stay within 32");
      end
      if (HI_W + 2 > DATA_W) begin : g_bad_hi
         $error("high word cannot hold the upper bits and both flags");
      end
      if (OFF_W < 3 || BASE_W < 1) begin : g_bad_win
         $error("window offset and base do not fit the data word");
      end
   endgenerate

   logic [ADDR_W-2:0] addr_q;
   logic              ext22_q;
   logic              map_q;
   logic [BASE_W-1:0] base_q;
   logic [1:0]        be_q;
   cafu_qual_t        qual;

   cafu_addr_reg #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .INC_EN (INC_EN)
   ) areg_i (
      .clk     (clk),
      .rst     (rst),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .adv     (adv),
      .wdata   (wdata),
      .addr_q  (addr_q),
      .ext22_q (ext22_q),
      .map_q   (map_q)
   );

   cafu_win_reg #(
      .DATA_W      (DATA_W),
      .OFF_W       (OFF_W),
      .IOPAGE_BITS (IOPAGE_BITS)
   ) wreg_i (
      .clk    (clk),
      .rst    (rst),
      .wr_win (wr_win),
      .wdata  (wdata),
      .base_q (base_q),
      .be_q   (be_q)
   );

   cafu_out_mux #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .OFF_W       (OFF_W),
      .IOPAGE_BITS (IOPAGE_BITS)
   ) omux_i (
      .win_mode (win_mode),
      .win_off  (win_off),
      .addr_q   (addr_q),
      .ext22_q  (ext22_q),
      .map_q    (map_q),
      .base_q   (base_q),
      .be_q     (be_q),
      .addr_o   (addr_o),
      .qual_o   (qual)
   );

   assign be_o     = qual.be;
   assign remote_o = qual.remote;
   assign ext22_o  = qual.ext22;
   assign mapen_o  = qual.mapen;

   // R1: the cycle after reset shows the cleared registers in normal mode
   p_reset_state_r1: assert property (@(posedge clk)
      ($past(rst) && !win_mode) |-> (addr_o == '0 && !ext22_o && !mapen_o));

endmodule

// File: tb/console_addr_unit_tb_top.sv
module console_addr_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_lo = 1'b0, wr_hi = 1'b0, wr_win = 1'b0, adv = 1'b0;
   logic [15:0] wdata = '0;
   logic        win_mode = 1'b0;
   logic [5:0]  win_off = '0;
   logic [20:0] addr_o;
   logic [1:0]  be_o;
   logic        remote_o, ext22_o, mapen_o;

   int n_checks = 0;
   int n_errors = 0;

   always #5 clk = ~clk;

   console_addr_unit dut_i (
      .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_win(wr_win),
      .adv(adv), .wdata(wdata), .win_mode(win_mode), .win_off(win_off),
      .addr_o(addr_o), .be_o(be_o), .remote_o(remote_o),
      .ext22_o(ext22_o), .mapen_o(mapen_o)
   );

   // op bits: 3 wr_lo, 2 wr_hi, 1 wr_win, 0 adv
   typedef struct packed {
      logic [3:0]  op;
      logic [15:0] wd;
      logic        wm;
      logic [5:0]  off;
      logic [20:0] ea;
      logic [1:0]  eb;
      logic        er;
      logic        e22;
      logic        emap;
      logic [3:0]  tag;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{4'h8, 16'h1234, 1'b0, 6'h00, 21'h00091A, 2'b11, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
      '{4'h4, 16'h00C5, 1'b0, 6'h00, 21'h02891A, 2'b11, 1'b0, 1'b1, 1'b1, 4'd3}, // R3
      '{4'h1, 16'h0000, 1'b0, 6'h00, 21'h02891B, 2'b11, 1'b0, 1'b1, 1'b1, 4'd8}, // R8
      '{4'h8, 16'hFFFE, 1'b0, 6'h00, 21'h007FFF, 2'b11, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
      '{4'h1, 16'h0000, 1'b0, 6'h00, 21'h008000, 2'b11, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 carry
      '{4'h4, 16'h003F, 1'b0, 6'h00, 21'h1F8000, 2'b11, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
      '{4'h8, 16'hFFFF, 1'b0, 6'h00, 21'h007FFF, 2'b11, 1'b0, 1'b0, 1'b0, 4'd2}, // R2
      '{4'h4, 16'h003F, 1'b0, 6'h00, 21'h1FFFFF, 2'b11, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
      '{4'h1, 16'h0000, 1'b0, 6'h00, 21'h000000, 2'b11, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 wrap
      '{4'h2, 16'h1541, 1'b1, 6'h2A, 21'h007AB5, 2'b01, 1'b1, 1'b0, 1'b0, 4'd5}, // R5 R4
      '{4'h2, 16'h0000, 1'b1, 6'h3F, 21'h00701F, 2'b11, 1'b1, 1'b0, 1'b0, 4'd4}, // R4
      '{4'hC, 16'h00C4, 1'b0, 6'h00, 21'h000062, 2'b11, 1'b0, 1'b0, 1'b0, 4'd9}, // R9
      '{4'h5, 16'h0041, 1'b0, 6'h00, 21'h008062, 2'b11, 1'b0, 1'b1, 1'b0, 4'd9}, // R9
      '{4'h0, 16'h0000, 1'b1, 6'h00, 21'h007000, 2'b11, 1'b1, 1'b0, 1'b0, 4'd6}, // R6
      '{4'h0, 16'h0000, 1'b0, 6'h00, 21'h008062, 2'b11, 1'b0, 1'b1, 1'b0, 4'd7}, // R7
      '{4'h9, 16'h0010, 1'b0, 6'h00, 21'h000008, 2'b11, 1'b0, 1'b0, 1'b0, 4'd9}, // R9
      '{4'h3, 16'h0042, 1'b0, 6'h00, 21'h000009, 2'b11, 1'b0, 1'b0, 1'b0, 4'd9}, // R9
      '{4'h0, 16'h0000, 1'b1, 6'h01, 21'h007020, 2'b10, 1'b1, 1'b0, 1'b0, 4'd5}  // R5
   };

   task automatic check(input string req, input logic [20:0] ea, input logic [1:0] eb,
                        input logic er, input logic e22, input logic emap);
      n_checks++;
      if (addr_o !== ea || be_o !== eb || remote_o !== er ||
          ext22_o !== e22 || mapen_o !== emap) begin
         n_errors++;
         $display("FAIL %s: got addr=%h be=%b rem=%b e22=%b map=%b, want addr=%h be=%b rem=%b e22=%b map=%b",
                  req, addr_o, be_o, remote_o, ext22_o, mapen_o, ea, eb, er, e22, emap);
      end
   endtask

   task automatic drop_strobes();
      wr_lo = 1'b0; wr_hi = 1'b0; wr_win = 1'b0; adv = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout, want completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: reset state, normal then window view
      check("R1", 21'h0, 2'b11, 1'b0, 1'b0, 1'b0);
      win_mode = 1'b1;
      #1;
      check("R1", 21'h007000, 2'b11, 1'b1, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {wr_lo, wr_hi, wr_win, adv} = VECS[i].op;
         wdata    = VECS[i].wd;
         win_mode = VECS[i].wm;
         win_off  = VECS[i].off;
         @(posedge clk);
         #1;
         drop_strobes();
         #2;
         check($sformatf("R%0d vec%0d", VECS[i].tag, i), VECS[i].ea, VECS[i].eb,
               VECS[i].er, VECS[i].e22, VECS[i].emap);
      end

      // R10: mode and offset reach the outputs with no clock edge between
      @(negedge clk);
      win_mode = 1'b0;
      #1;
      check("R10", 21'h000009, 2'b11, 1'b0, 1'b0, 1'b0);
      win_mode = 1'b1;
      win_off  = 6'h3E;
      #1;
      check("R10", 21'h00703F, 2'b10, 1'b1, 1'b0, 1'b0);
      // R5: offset bit 0 is ignored
      win_off = 6'h3F;
      #1;
      check("R5", 21'h00703F, 2'b10, 1'b1, 1'b0, 1'b0);
      // R10: a write strobe alone does not show before the edge
      win_mode = 1'b0;
      wr_lo = 1'b1;
      wdata = 16'h0AAA;
      #1;
      check("R10", 21'h000009, 2'b11, 1'b0, 1'b0, 1'b0);
      @(posedge clk);
      #1;
      drop_strobes();
      #2;
      check("R10", 21'h000555, 2'b11, 1'b0, 1'b0, 1'b0);

      // R1: reset wins over strobes and restores the window defaults
      @(negedge clk);
      wr_hi = 1'b1;
      wr_win = 1'b1;
      wdata = 16'h00FF;
      rst = 1'b1;
      @(posedge clk);
      #1;
      drop_strobes();
      rst = 1'b0;
      #2;
      check("R1", 21'h0, 2'b11, 1'b0, 1'b0, 1'b0);
      win_mode = 1'b1;
      win_off  = 6'h00;
      #1;
      check("R1", 21'h007000, 2'b11, 1'b1, 1'b0, 1'b0);

      @(negedge clk);
      finish_run();
   end

endmodule